// File: doc/BRIEF.md
# SPI Hold Gate

This block sits between the pins of an SPI slave and the shift engine behind it, and lets the bus master pause a transfer without losing its place. It samples the serial clock, the active-low chip select, the active-low pause input and the data input with the system clock. From these it produces a registered pause flag and clock-edge strobes that the pause gates off. It also builds the output enable for the serial data line, which the pause forces off.

The pause state is updated only while the serial clock is low. A pause request that arrives while the clock is high waits for the next falling clock edge, and the same applies to a release. The block tracks the bit position within the current word. That position and the partly received word are frozen during a pause, so shifting resumes on the following bit. Releasing chip select during a pause issues a one-cycle reset pulse to the slave engine and clears the position. Instruction decoding and storage belong to the engine and are not part of this block.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset, `hold_active`, `sdo_oe`, `shift_stb`, `drive_stb`, `word_valid` and `engine_rst` are 0, and `bit_pos` is 0.
- R2: While selected (`cs_n` low) with `sclk` low, driving `hold_n` low sets `hold_active` to 1.
- R3: If `hold_n` goes low while `sclk` is high, `hold_active` stays 0 until `sclk` falls. That falling edge raises `hold_active` and produces no `drive_stb`.
- R4: While `hold_active` is 1, edges on `sclk` and values on `mosi` have no effect: no `shift_stb` or `drive_stb` pulses occur, `bit_pos` does not change, and `sdo_oe` is 0.
- R5: With `sclk` low, driving `hold_n` high clears `hold_active`. If `hold_n` rises while `sclk` is high, `hold_active` stays 1 until `sclk` falls.
- R6: After a pause ends, `bit_pos` continues from its frozen value. The word presented on `word_valid` holds exactly the bits sampled on non-paused rising edges, first bit in the MSB.
- R7: Raising `cs_n` while `hold_active` is 1 produces exactly one single-cycle `engine_rst` pulse, clears `hold_active`, and returns `bit_pos` to 0.
- R8: Raising `cs_n` with no pause active clears `bit_pos` and produces no `engine_rst` pulse.
- R9: While deselected (`cs_n` high), `hold_n` low leaves `hold_active` at 0.
- R10: `sdo_oe` equals `engine_oe` when the block is selected and not paused, and is 0 otherwise. `sdo` follows `engine_sdo`.
- R11: Every WORD_W-th non-paused rising edge of `sclk` since selection gives a one-cycle `word_valid` pulse. `bit_pos` counts from 0 to WORD_W-1 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock pin |
| cs_n | input | 1 | Chip select pin, active low |
| hold_n | input | 1 | Pause request pin, active low |
| mosi | input | 1 | Serial data input pin |
| engine_sdo | input | 1 | Output bit from the slave engine |
| engine_oe | input | 1 | Output enable request from the slave engine |
| sdo | output | 1 | Registered serial data output |
| sdo_oe | output | 1 | Registered output enable for the serial data pin |
| hold_active | output | 1 | Registered pause flag |
| shift_stb | output | 1 | Gated rising-edge strobe for the engine |
| drive_stb | output | 1 | Gated falling-edge strobe for the engine |
| engine_rst | output | 1 | One-cycle reset pulse to the engine |
| bit_pos | output | $clog2(WORD_W) | Bit position within the current word |
| rx_word | output | WORD_W | Last completed received word |
| word_valid | output | 1 | One-cycle pulse when rx_word updates |

## Verification
The bench builds the block with WORD_W = 8 and SYNC_STAGES = 3. The deeper synchronizer shows that the gating stays correct when every pin is delayed by an extra register. With 8-bit words, a pause can be placed in the middle of a word: after three bits, and after five bits with the request made on a high clock. Both the frozen position and the resumed word can then be checked. Separate sequences abort a paused transfer, deselect without a pause, and assert the pause pin while deselected.

// File: rtl/hold_gate_pkg.sv
package hold_gate_pkg;
  typedef struct packed {
    logic sclk;
    logic cs_n;
    logic hold_n;
    logic mosi;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);
  localparam pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, hold_n: 1'b1, mosi: 1'b0};
endpackage

// File: rtl/hold_gate_sync.sv
module hold_gate_sync #(
  parameter int STAGES = 2,
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hold_gate_core.sv
module hold_gate_core
  import hold_gate_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  pins_t s,
  output logic  held,
  output logic  held_nxt,
  output logic  shift_stb,
  output logic  drive_stb,
  output logic  engine_rst
);
  logic sclk_q, cs_q;

  always_comb begin
    if (s.cs_n)       held_nxt = 1'b0;
    else if (!s.sclk) held_nxt = !s.hold_n;
    else              held_nxt = held;
  end

  assign shift_stb = s.sclk & ~sclk_q & ~s.cs_n & ~held_nxt;
  assign drive_stb = ~s.sclk & sclk_q & ~s.cs_n & ~held_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      held       <= 1'b0;
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      engine_rst <= 1'b0;
    end else begin
      held       <= held_nxt;
      sclk_q     <= s.sclk;
      cs_q       <= s.cs_n;
      engine_rst <= held & s.cs_n & ~cs_q;
    end
  end

  a_r3_enter_on_low_clock: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> $past(!s.sclk));
  a_r5_exit_on_low_clock: assert property (@(posedge clk) disable iff (rst)
    ($fell(held) && $past(!s.cs_n)) |-> $past(!s.sclk));
  a_r9_deselect_clears: assert property (@(posedge clk) disable iff (rst)
    s.cs_n |=> !held);
  a_r4_no_strobe_held: assert property (@(posedge clk) disable iff (rst)
    held && !s.cs_n && !($fell(s.sclk) && s.hold_n) |-> !shift_stb && !drive_stb);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    engine_rst |=> !engine_rst);
endmodule

// File: rtl/hold_gate_track.sv
module hold_gate_track #(
  parameter int WORD_W = 8,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  input  logic              din,
  output logic [POS_W-1:0]  pos,
  output logic [WORD_W-1:0] word,
  output logic              valid
);
  localparam logic [POS_W-1:0] LAST = POS_W'(WORD_W - 1);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      shreg <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (clr) begin
        pos <= '0;
      end else if (adv) begin
        shreg <= {shreg[WORD_W-2:0], din};
        if (pos == LAST) begin
          pos   <= '0;
          word  <= {shreg[WORD_W-2:0], din};
          valid <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  a_r11_pos_in_range: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST);
  a_r4_pos_frozen: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(pos));
  a_r8_clear_pos: assert property (@(posedge clk) disable iff (rst)
    clr |=> pos == '0);
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import hold_gate_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              mosi,
  input  logic              engine_sdo,
  input  logic              engine_oe,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              hold_active,
  output logic              shift_stb,
  output logic              drive_stb,
  output logic              engine_rst,
  output logic [POS_W-1:0]  bit_pos,
  output logic [WORD_W-1:0] rx_word,
  output logic              word_valid
);
  pins_t raw, syn;
  logic  held_nxt;

  assign raw = '{sclk: sclk, cs_n: cs_n, hold_n: hold_n, mosi: mosi};

  hold_gate_sync #(.STAGES(SYNC_STAGES), .W(PINS_W), .RST_VAL(PINS_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  hold_gate_core u_core (
    .clk(clk), .rst(rst), .s(syn),
    .held(hold_active), .held_nxt(held_nxt),
    .shift_stb(shift_stb), .drive_stb(drive_stb), .engine_rst(engine_rst)
  );

  hold_gate_track #(.WORD_W(WORD_W)) u_track (
    .clk(clk), .rst(rst), .clr(syn.cs_n), .adv(shift_stb), .din(syn.mosi),
    .pos(bit_pos), .word(rx_word), .valid(word_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      sdo    <= engine_sdo;
      sdo_oe <= ~syn.cs_n & ~held_nxt & engine_oe;
    end
  end

  a_r10_oe_off_in_hold: assert property (@(posedge clk) disable iff (rst)
    hold_active |-> !sdo_oe);
  a_r7_abort_clears_hold: assert property (@(posedge clk) disable iff (rst)
    engine_rst |-> !hold_active && bit_pos == '0);
endmodule

// File: tb/spi_hold_gate_tb_top.sv
module spi_hold_gate_tb_top;
  localparam int W = 8;
  localparam int HALF = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, hold_n = 1'b1, mosi = 1'b0;
  logic engine_sdo = 1'b0, engine_oe = 1'b0;
  logic sdo, sdo_oe, hold_active, shift_stb, drive_stb, engine_rst, word_valid;
  logic [$clog2(W)-1:0] bit_pos;
  logic [W-1:0] rx_word;

  int checks = 0, failures = 0;
  int n_shift = 0, n_drive = 0, n_rst = 0;
  logic [W-1:0] expq [$];

  always #10 clk = ~clk;

  spi_hold_gate #(.WORD_W(W), .SYNC_STAGES(3)) dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .hold_n(hold_n), .mosi(mosi),
    .engine_sdo(engine_sdo), .engine_oe(engine_oe), .sdo(sdo), .sdo_oe(sdo_oe),
    .hold_active(hold_active), .shift_stb(shift_stb), .drive_stb(drive_stb),
    .engine_rst(engine_rst), .bit_pos(bit_pos), .rx_word(rx_word), .word_valid(word_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: counts strobes and pops the scoreboard on each completed word
  always @(negedge clk) begin
    if (!rst) begin
      if (shift_stb) n_shift++;
      if (drive_stb) n_drive++;
      if (engine_rst) n_rst++;
      if (word_valid) begin
        if (expq.size() == 0) chk(1'b0, "R6 unexpected word", int'(rx_word), -1);
        else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          chk(rx_word == e, "R6/R11 word", int'(rx_word), int'(e));
        end
      end
    end
  end

  task automatic settle();
    repeat (HALF) @(posedge clk);
    #3;
  endtask

  task automatic clk_bit(input logic b);
    mosi = b; settle();
    sclk = 1'b1; settle();
    sclk = 1'b0; settle();
  endtask

  task automatic tx_bits(input logic [W-1:0] v, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) clk_bit(v[i]);
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s0, f0, r0;
    repeat (4) @(posedge clk);
    #3;
    chk(hold_active == 0 && sdo_oe == 0 && bit_pos == 0, "R1 reset outputs", int'(hold_active), 0);
    chk(shift_stb == 0 && drive_stb == 0 && word_valid == 0 && engine_rst == 0, "R1 reset strobes", int'(shift_stb), 0);
    rst = 1'b0; settle();

    // R9: pause pin while deselected
    hold_n = 1'b0; settle();
    chk(hold_active == 0, "R9 no hold while deselected", int'(hold_active), 0);
    hold_n = 1'b1; settle();
    chk(sdo_oe == 0, "R10 oe off while deselected", int'(sdo_oe), 0);

    // plain word
    engine_oe = 1'b1; engine_sdo = 1'b1;
    cs_n = 1'b0; settle();
    chk(sdo_oe == 1 && sdo == 1, "R10 oe follows engine", int'(sdo_oe), 1);
    expq.push_back(8'hA5);
    tx_bits(8'hA5, 7, 0);
    chk(bit_pos == 0, "R11 wrap after word", int'(bit_pos), 0);

    // R2/R4/R6: pause after three bits
    expq.push_back(8'h3C);
    tx_bits(8'h3C, 7, 5);
    chk(bit_pos == 3, "R11 position", int'(bit_pos), 3);
    hold_n = 1'b0; settle();
    chk(hold_active == 1, "R2 hold entered", int'(hold_active), 1);
    chk(sdo_oe == 0, "R4 oe off in hold", int'(sdo_oe), 0);
    s0 = n_shift; f0 = n_drive;
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
    chk(n_shift == s0 && n_drive == f0, "R4 strobes gated", n_shift - s0, 0);
    chk(bit_pos == 3, "R4 position frozen", int'(bit_pos), 3);
    hold_n = 1'b1; settle();
    chk(hold_active == 0 && sdo_oe == 1, "R5 hold released", int'(hold_active), 0);
    tx_bits(8'h3C, 4, 0);

    // R3/R5: requests made on a high clock
    expq.push_back(8'hC9);
    tx_bits(8'hC9, 7, 4);
    mosi = 1'b1; settle();
    sclk = 1'b1; settle();
    chk(bit_pos == 5, "R6 position before pause", int'(bit_pos), 5);
    hold_n = 1'b0; settle();
    chk(hold_active == 0, "R3 no entry on high clock", int'(hold_active), 0);
    f0 = n_drive;
    sclk = 1'b0; settle();
    chk(hold_active == 1, "R3 entry at falling edge", int'(hold_active), 1);
    chk(n_drive == f0, "R3 entry edge swallowed", n_drive - f0, 0);
    sclk = 1'b1; settle();
    hold_n = 1'b1; settle();
    chk(hold_active == 1, "R5 no exit on high clock", int'(hold_active), 1);
    sclk = 1'b0; settle();
    chk(hold_active == 0, "R5 exit at falling edge", int'(hold_active), 0);
    chk(bit_pos == 5, "R6 resume position", int'(bit_pos), 5);
    tx_bits(8'hC9, 2, 0);

    // R7: deselect during pause
    tx_bits(8'hFF, 7, 6);
    hold_n = 1'b0; settle();
    r0 = n_rst;
    cs_n = 1'b1; settle();
    chk(n_rst == r0 + 1, "R7 one reset pulse", n_rst - r0, 1);
    chk(hold_active == 0 && bit_pos == 0, "R7 state cleared", int'(bit_pos), 0);
    hold_n = 1'b1; settle();

    // R8: deselect without pause
    cs_n = 1'b0; settle();
    tx_bits(8'h0F, 7, 5);
    r0 = n_rst;
    cs_n = 1'b1; settle();
    chk(n_rst == r0, "R8 no reset pulse", n_rst - r0, 0);
    chk(bit_pos == 0, "R8 position cleared", int'(bit_pos), 0);

    settle();
    chk(expq.size() == 0, "R6 all words seen", expq.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule